// File: doc/BRIEF.md
# Signed Remainder and Modulus Unit

This block divides a signed dividend by a signed divisor and returns two remainder conventions from the same pass. The truncated remainder carries the sign of the dividend. The floored modulus carries the sign of the divisor. The truncated quotient is also output. The divide works on magnitudes, one restoring step per clock. A final cycle then applies the sign corrections, derives the modulus from the remainder, and registers all results together.

A caller presents both operands and pulses `start` for one cycle while the unit is idle. The unit raises `busy`. Exactly `WIDTH + 1` clock edges after the edge that accepted `start`, it presents the results with a one-cycle `done` pulse. A zero divisor still takes the same path and the same latency. It raises the divide-by-zero flag and returns zero for every result. All results stay unchanged until the next operation completes.

Top module: `sdm_unit`

## Requirements
- R1: When `rem_out` is nonzero, its sign bit (bit WIDTH-1) equals the sign bit of the dividend accepted at `start`.
- R2: When `mod_out` is nonzero, its sign bit (bit WIDTH-1) equals the sign bit of the accepted divisor.
- R3: For a nonzero divisor, the absolute values of `rem_out` and `mod_out` are both strictly less than the absolute value of the divisor.
- R4: `quo_out` is the quotient truncated toward zero, and `rem_out` equals dividend minus `quo_out` times divisor. For example, 8,5 → rem 3; -8,5 → rem -3; 8,-5 → rem 3; -8,-5 → rem -3.
- R5: `mod_out` equals `rem_out` plus the divisor when `rem_out` is nonzero and its sign differs from the divisor's sign. Otherwise it equals `rem_out`. For example, 8,5 → 3; -8,5 → 2; 8,-5 → -2; -8,-5 → -3.
- R6: `done` is a single-cycle pulse that is high in the cycle after the (WIDTH+1)-th clock edge following the edge that accepted `start`. `busy` is high from the accepting edge until `done` rises.
- R7: A zero divisor sets `div_zero`, forces `rem_out`, `mod_out` and `quo_out` to zero, and still completes with `done` at the R6 latency. A nonzero divisor clears `div_zero`.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running operation completes with its original operands and produces no extra `done`.
- R9: After reset all result outputs, `div_zero`, `done` and `busy` are zero. Results hold their values between `done` pulses, even when the operand inputs change.
- R10: The most negative dividend (-2^(WIDTH-1)) is handled exactly. Dividing it by -1 gives remainder 0, modulus 0, and a quotient that wraps to -2^(WIDTH-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only while idle) |
| dividend | input | WIDTH | Signed dividend, two's complement |
| divisor | input | WIDTH | Signed divisor, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid and updated |
| rem_out | output | WIDTH | Truncated remainder, sign of dividend |
| mod_out | output | WIDTH | Floored modulus, sign of divisor |
| quo_out | output | WIDTH | Quotient truncated toward zero |
| div_zero | output | 1 | Last operation had a zero divisor |

## Verification
All results (`done`, `rem_out`, `mod_out`, `quo_out` and `div_zero`) change together on the (WIDTH+1)-th rising edge after the edge that accepts `start`, so they are due nine edges later at the default width. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the accepting edge, expects `done` exactly at index WIDTH+1, and requires it to be low at every index before that and at the index after. Every result value is read in that `done` cycle. The hold and ignored-start cases are read at the ports over several later cycles.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [1:0] {
        SDM_IDLE = 2'd0,
        SDM_RUN  = 2'd1,
        SDM_FIX  = 2'd2
    } sdm_state_e;

endpackage

// File: rtl/sdm_ctrl.sv
module sdm_ctrl
    import sdm_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy
);

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        sdm_state_e     st;
        logic [CW-1:0]  cnt;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        step  = 1'b0;
        fix   = 1'b0;
        case (ctl_q.st)
            SDM_IDLE: begin
                if (start) begin
                    load       = 1'b1;
                    ctl_d.st   = SDM_RUN;
                    ctl_d.cnt  = '0;
                end
            end
            SDM_RUN: begin
                step = 1'b1;
                if (ctl_q.cnt == LAST) begin
                    ctl_d.st = SDM_FIX;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CW'(1);
                end
            end
            SDM_FIX: begin
                fix      = 1'b1;
                ctl_d.st = SDM_IDLE;
            end
            default: ctl_d.st = SDM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= SDM_IDLE;
            ctl_q.cnt <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = (ctl_q.st != SDM_IDLE);

    // R6: the iteration counter never passes the last step
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == SDM_RUN) |-> (ctl_q.cnt <= LAST));

    // R6: the correction cycle always directly follows an iteration
    p_fix_after_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fix |-> $past(step));

    // R8: a new operation is never loaded while one is running
    p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step || fix) |-> !load);

endmodule

// File: rtl/sdm_step.sv
module sdm_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] part_rem,
    input  logic [WIDTH-1:0] quo_sr,
    input  logic [WIDTH-1:0] dmag,
    output logic [WIDTH-1:0] next_rem,
    output logic [WIDTH-1:0] next_quo
);

    logic [WIDTH:0] shifted;
    logic [WIDTH:0] trial;
    logic           qbit;

    always_comb begin
        shifted = {part_rem, quo_sr[WIDTH-1]};
        trial   = shifted - {1'b0, dmag};
        qbit    = ~trial[WIDTH];
        if (qbit) begin
            next_rem = trial[WIDTH-1:0];
        end else begin
            next_rem = shifted[WIDTH-1:0];
        end
        next_quo = {quo_sr[WIDTH-2:0], qbit};
    end

endmodule

// File: rtl/sdm_fixup.sv
module sdm_fixup #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rmag,
    input  logic [WIDTH-1:0] qmag,
    input  logic             neg_a,
    input  logic [WIDTH-1:0] bval,
    input  logic             zero_div,
    output logic [WIDTH-1:0] rem_v,
    output logic [WIDTH-1:0] mod_v,
    output logic [WIDTH-1:0] quo_v
);

    logic             neg_b;
    logic [WIDTH-1:0] r_signed;
    logic [WIDTH-1:0] q_signed;
    logic             wrap;

    always_comb begin
        neg_b    = bval[WIDTH-1];
        r_signed = neg_a ? (~rmag + WIDTH'(1)) : rmag;
        q_signed = (neg_a ^ neg_b) ? (~qmag + WIDTH'(1)) : qmag;
        wrap     = (r_signed != '0) && (r_signed[WIDTH-1] != neg_b);
        if (zero_div) begin
            rem_v = '0;
            mod_v = '0;
            quo_v = '0;
        end else begin
            rem_v = r_signed;
            mod_v = wrap ? (r_signed + bval) : r_signed;
            quo_v = q_signed;
        end
    end

endmodule

// File: rtl/sdm_unit.sv
module sdm_unit #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] rem_out,
    output logic [WIDTH-1:0] mod_out,
    output logic [WIDTH-1:0] quo_out,
    output logic             div_zero
);

    typedef struct packed {
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] dmag;
        logic [WIDTH-1:0] prem;
        logic [WIDTH-1:0] pquo;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] mdl;
        logic [WIDTH-1:0] quo;
        logic             zd;
        logic             dz;
        logic             done;
    } dp_s;

    function automatic logic [WIDTH-1:0] mag(input logic [WIDTH-1:0] v);
        return v[WIDTH-1] ? (~v + WIDTH'(1)) : v;
    endfunction

    dp_s dp_d, dp_q;

    logic             load, step, fix;
    logic [WIDTH-1:0] st_rem, st_quo;
    logic [WIDTH-1:0] fx_rem, fx_mod, fx_quo;

    sdm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .busy  (busy)
    );

    sdm_step #(.WIDTH(WIDTH)) u_step (
        .part_rem (dp_q.prem),
        .quo_sr   (dp_q.pquo),
        .dmag     (dp_q.dmag),
        .next_rem (st_rem),
        .next_quo (st_quo)
    );

    sdm_fixup #(.WIDTH(WIDTH)) u_fix (
        .rmag     (dp_q.prem),
        .qmag     (dp_q.pquo),
        .neg_a    (dp_q.a[WIDTH-1]),
        .bval     (dp_q.b),
        .zero_div (dp_q.zd),
        .rem_v    (fx_rem),
        .mod_v    (fx_mod),
        .quo_v    (fx_quo)
    );

    always_comb begin
        dp_d      = dp_q;
        dp_d.done = 1'b0;
        if (load) begin
            dp_d.a    = dividend;
            dp_d.b    = divisor;
            dp_d.dmag = mag(divisor);
            dp_d.pquo = mag(dividend);
            dp_d.prem = '0;
            dp_d.zd   = (divisor == '0);
        end
        if (step) begin
            dp_d.prem = st_rem;
            dp_d.pquo = st_quo;
        end
        if (fix) begin
            dp_d.rem  = fx_rem;
            dp_d.mdl  = fx_mod;
            dp_d.quo  = fx_quo;
            dp_d.dz   = dp_q.zd;
            dp_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign done     = dp_q.done;
    assign rem_out  = dp_q.rem;
    assign mod_out  = dp_q.mdl;
    assign quo_out  = dp_q.quo;
    assign div_zero = dp_q.dz;

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_rem_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (rem_out != '0)) |-> (rem_out[WIDTH-1] == dp_q.a[WIDTH-1]));

    p_mod_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mod_out != '0)) |-> (mod_out[WIDTH-1] == dp_q.b[WIDTH-1]));

    p_mag_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |->
            ((mag(rem_out) < mag(dp_q.b)) && (mag(mod_out) < mag(dp_q.b))));

    p_zero_results_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> ((rem_out == '0) && (mod_out == '0) && (quo_out == '0)));

    p_operands_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(dp_q.a) && $stable(dp_q.b)));

    p_results_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rem_out) && $stable(mod_out) && $stable(quo_out) && $stable(div_zero)));

endmodule

// File: tb/tb_sdm_unit.sv
module tb_sdm_unit;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [W-1:0] rem_out, mod_out, quo_out;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sdm_unit #(.WIDTH(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .busy     (busy),
        .done     (done),
        .rem_out  (rem_out),
        .mod_out  (mod_out),
        .quo_out  (quo_out),
        .div_zero (div_zero)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int sx(input logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int wrapw(input int v);
        logic [W-1:0] t;
        t = W'(v);
        return int'($signed(t));
    endfunction

    // Issues one operation and checks R6 timing plus R1..R5, R7, R10 values
    task automatic run_op(input int a, input int b, input string tag);
        int er, em, eq, ez, lat;
        if (b == 0) begin
            er = 0; em = 0; eq = 0; ez = 1;
        end else begin
            eq = wrapw(a / b);
            er = a - (a / b) * b;
            em = ((er != 0) && ((er < 0) != (b < 0))) ? er + b : er;
            ez = 0;
        end
        @(negedge clk);
        dividend = W'(a);
        divisor  = W'(b);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int n = 1; n <= W + 4; n++) begin
            @(negedge clk);
            if (n == 1) chk({tag, " R6 busy while running"}, int'(busy), 1);
            if (done) begin
                lat = n;
                break;
            end
        end
        chk({tag, " R6 done latency"}, lat, W + 1);
        chk({tag, " R1 R4 remainder"}, sx(rem_out), er);
        chk({tag, " R2 R5 modulus"}, sx(mod_out), em);
        chk({tag, " R4 quotient"}, sx(quo_out), eq);
        chk({tag, " R7 div_zero flag"}, int'(div_zero), ez);
        if (b != 0) begin
            chk({tag, " R3 rem bound"}, int'((er < 0 ? -er : er) < (b < 0 ? -b : b)), 1);
        end
        @(negedge clk);
        chk({tag, " R6 single pulse"}, int'(done), 0);
        chk({tag, " R6 idle after done"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        chk("R9 reset done", int'(done), 0);
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset rem", sx(rem_out), 0);
        chk("R9 reset mod", sx(mod_out), 0);
        chk("R9 reset quo", sx(quo_out), 0);
        chk("R9 reset div_zero", int'(div_zero), 0);
    endtask

    task automatic t_table();
        run_op(8, 5, "tbl +8/+5");
        run_op(-8, 5, "tbl -8/+5");
        run_op(8, -5, "tbl +8/-5");
        run_op(-8, -5, "tbl -8/-5");
    endtask

    task automatic t_sweep();
        run_op(127, 3, "sw 127/3");
        run_op(-127, 10, "sw -127/10");
        run_op(7, 9, "sw small 7/9");
        run_op(-7, 9, "sw small -7/9");
        run_op(0, -5, "sw zero dividend");
        run_op(50, -50, "sw exact");
        run_op(-1, 127, "sw -1/127");
        run_op(99, 1, "sw unit divisor");
    endtask

    task automatic t_extreme();
        run_op(-128, -1, "R10 -128/-1");
        run_op(-128, 7, "R10 -128/7");
        run_op(5, -128, "R10 5/-128");
        run_op(-128, -128, "R10 -128/-128");
    endtask

    task automatic t_zero();
        run_op(42, 0, "R7 42/0");
        run_op(-128, 0, "R7 -128/0");
        run_op(9, 4, "R7 flag clears");
    endtask

    task automatic t_busy();
        int lat, extra;
        @(negedge clk);
        dividend = W'(100);
        divisor  = W'(7);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int n = 1; n <= W + 4; n++) begin
            @(negedge clk);
            if (n == 3) begin
                dividend = W'(-9);
                divisor  = W'(2);
                start    = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                lat = n;
                break;
            end
        end
        start = 1'b0;
        chk("R8 latency with stray start", lat, W + 1);
        chk("R8 remainder of first op", sx(rem_out), 2);
        chk("R8 modulus of first op", sx(mod_out), 2);
        chk("R8 quotient of first op", sx(quo_out), 14);
        extra = 0;
        for (int n = 0; n < W + 3; n++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R8 no extra done", extra, 0);
    endtask

    task automatic t_hold();
        run_op(-8, 5, "R9 hold setup");
        dividend = W'(77);
        divisor  = W'(-3);
        repeat (10) @(negedge clk);
        chk("R9 rem held", sx(rem_out), -3);
        chk("R9 mod held", sx(mod_out), 2);
        chk("R9 quo held", sx(quo_out), -1);
        chk("R9 no done without start", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_table();
        t_sweep();
        t_extreme();
        t_zero();
        t_busy();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule